// File: doc/BRIEF.md
# Framed Serial Control Port Master

This block is a full-duplex serial master for programming and reading back a peripheral over a three-wire link plus a frame strobe. The strobe serves as the chip select. The block divides the system clock down to a free-running bit clock. Each transmit word arrives over a valid/ready handshake and goes into a one-word holding buffer. Each such word produces exactly one frame: an active-low, late frame strobe and sixteen bits shifted out most significant bit first.

During the same frame the block shifts in one word from the serial input. It reuses its own generated bit clock and frame strobe for this, so both directions are framed identically. The received word is presented on a parallel output with a single-cycle valid strobe. Transmit data changes on falling bit-clock edges and input data is sampled on rising edges. If another word is already buffered when a frame ends, the next frame follows with no idle bit between them.

The serial rate is set by `clk_div`. Each half period of the bit clock lasts `clk_div + 1` system cycles, so the bit rate is f_clk / (2·(clk_div+1)).

Top module: `fsp_master`

## Requirements
- R1: After reset `sclk` is low and free-running. It toggles once every `clk_div + 1` system clock cycles, whether or not a frame is active.
- R2: While `rst_n` is low: `sclk` = 0, `fs_n` = 1, `sdo` = 0, `tx_ready` = 1, `rx_valid` = 0.
- R3: `tx_ready` is high exactly when the one-word holding buffer is empty. A word is taken on a clock edge where `tx_valid` and `tx_ready` are both high, and `tx_ready` is low on the following cycle.
- R4: A frame starts only on a falling `sclk` edge while a word is buffered. With no buffered word, `fs_n` stays high. `fs_n` changes only on system cycles where `sclk` falls.
- R5: Late frame sync: `fs_n` goes low on the same system edge where `sdo` takes bit 15 of the word. It stays low through exactly 16 rising `sclk` edges.
- R6: `sdo` changes only together with a falling `sclk` edge. It presents the word from bit 15 down to bit 0 and keeps the last bit while idle.
- R7: If a word is buffered when a frame's 16th bit period ends, the next frame starts on that same falling edge. `fs_n` stays low across the boundary.
- R8: `sdi` is sampled on every rising `sclk` edge while `fs_n` is low. The first sample lands in bit 15 of `rx_data`.
- R9: `rx_valid` is a one-system-cycle pulse. It is high in the cycle right after the 16th rising edge of a frame, with the completed word on `rx_data`.
- R10: A new `clk_div` value applied just after an `sclk` toggle sets the length of the next half period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_div | input | DIV_W | Half-period length of `sclk` minus one, in system cycles |
| tx_valid | input | 1 | Transmit word offered |
| tx_ready | output | 1 | Holding buffer empty, word can be taken |
| tx_data | input | WORD_W | Transmit word |
| rx_valid | output | 1 | One-cycle strobe: received word complete |
| rx_data | output | WORD_W | Last received word |
| sclk | output | 1 | Serial bit clock |
| fs_n | output | 1 | Active-low late frame sync / chip select |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |

## Verification
A corrupted half-period counter appears on the very next `sclk` toggle as a wrong interval. A wrong bit index or shift register shows up within one bit period as a mismatched `sdo` bit, or as `fs_n` lasting the wrong number of rising edges. A stale holding-buffer flag shows at once as `tx_ready` disagreeing with the reference queue, or later as a missing or extra frame. A receive counter that is out of step moves or duplicates the `rx_valid` pulse by whole bit periods, and `rx_data` then no longer matches the word the bench shifted in.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

   typedef enum logic {
      TX_IDLE = 1'b0,
      TX_BUSY = 1'b1
   } tx_state_e;

   // width of a counter that must reach n-1
   function automatic int unsigned cnt_width(int unsigned n);
      return (n <= 1) ? 1 : $clog2(n);
   endfunction

endpackage

// File: rtl/fsp_bitclk.sv
module fsp_bitclk #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [DIV_W-1:0] half_div,
   output logic             sclk,
   output logic             rise_tick,
   output logic             fall_tick
);

   logic [DIV_W-1:0] cnt_q;
   logic             sclk_q;
   logic             wrap;

   assign wrap = (cnt_q >= half_div);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         sclk_q <= 1'b0;
      end else if (wrap) begin
         cnt_q  <= '0;
         sclk_q <= ~sclk_q;
      end else begin
         cnt_q  <= cnt_q + 1'b1;
      end
   end

   // strobes mark the system cycle whose closing edge moves sclk
   assign rise_tick = wrap & ~sclk_q;
   assign fall_tick = wrap &  sclk_q;
   assign sclk      = sclk_q;

endmodule

// File: rtl/fsp_txpath.sv
module fsp_txpath
   import fsp_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fall_tick,
   input  logic              tx_valid,
   input  logic [WORD_W-1:0] tx_data,
   output logic              tx_ready,
   output logic              fs_n,
   output logic              sdo
);

   localparam int unsigned      IDX_W    = cnt_width(WORD_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

   logic [WORD_W-1:0] hold_q;
   logic [WORD_W-1:0] shift_q;
   logic              hold_full_q;
   tx_state_e         st_q;
   logic [IDX_W-1:0]  idx_q;
   logic              fs_n_q;
   logic              sdo_q;
   logic              accept;
   logic              last_bit;
   logic              start;

   assign accept   = tx_valid && !hold_full_q;
   assign last_bit = (st_q == TX_BUSY) && (idx_q == LAST_IDX);
   assign start    = fall_tick && hold_full_q && ((st_q == TX_IDLE) || last_bit);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hold_q      <= '0;
         hold_full_q <= 1'b0;
      end else if (accept) begin
         hold_q      <= tx_data;
         hold_full_q <= 1'b1;
      end else if (start) begin
         hold_full_q <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q    <= TX_IDLE;
         idx_q   <= '0;
         shift_q <= '0;
         fs_n_q  <= 1'b1;
         sdo_q   <= 1'b0;
      end else if (start) begin
         st_q    <= TX_BUSY;
         idx_q   <= '0;
         sdo_q   <= hold_q[WORD_W-1];
         shift_q <= {hold_q[WORD_W-2:0], 1'b0};
         fs_n_q  <= 1'b0;
      end else if (fall_tick && (st_q == TX_BUSY)) begin
         if (last_bit) begin
            st_q   <= TX_IDLE;
            fs_n_q <= 1'b1;
         end else begin
            idx_q   <= idx_q + 1'b1;
            sdo_q   <= shift_q[WORD_W-1];
            shift_q <= {shift_q[WORD_W-2:0], 1'b0};
         end
      end
   end

   assign tx_ready = !hold_full_q;
   assign fs_n     = fs_n_q;
   assign sdo      = sdo_q;

endmodule

// File: rtl/fsp_rxpath.sv
module fsp_rxpath
   import fsp_pkg::*;
#(
   parameter int WORD_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_strobe,
   input  logic              fs_n,
   input  logic              sdi,
   output logic              rx_valid,
   output logic [WORD_W-1:0] rx_data
);

   localparam int unsigned      IDX_W    = cnt_width(WORD_W);
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(WORD_W - 1);

   logic [WORD_W-1:0] sh_q;
   logic [WORD_W-1:0] word_q;
   logic [IDX_W-1:0]  idx_q;
   logic              valid_q;
   logic [WORD_W-1:0] sh_next;

   assign sh_next = {sh_q[WORD_W-2:0], sdi};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         sh_q    <= '0;
         word_q  <= '0;
         idx_q   <= '0;
         valid_q <= 1'b0;
      end else begin
         valid_q <= 1'b0;
         if (bit_strobe && !fs_n) begin
            sh_q <= sh_next;
            if (idx_q == LAST_IDX) begin
               idx_q   <= '0;
               word_q  <= sh_next;
               valid_q <= 1'b1;
            end else begin
               idx_q <= idx_q + 1'b1;
            end
         end else if (fs_n) begin
            idx_q <= '0;
         end
      end
   end

   assign rx_valid = valid_q;
   assign rx_data  = word_q;

endmodule

// File: rtl/fsp_master.sv
module fsp_master #(
   parameter int WORD_W = 16,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DIV_W-1:0]  clk_div,
   input  logic              tx_valid,
   output logic              tx_ready,
   input  logic [WORD_W-1:0] tx_data,
   output logic              rx_valid,
   output logic [WORD_W-1:0] rx_data,
   output logic              sclk,
   output logic              fs_n,
   output logic              sdo,
   input  logic              sdi
);

   generate
      if (WORD_W < 2) begin : g_bad_word
         $error("fsp_master: WORD_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_bad_div
         $error("fsp_master: DIV_W must be at least 1");
      end
   endgenerate

   logic rise_tick;
   logic fall_tick;
   logic fs_n_int;

   fsp_bitclk #(.DIV_W(DIV_W)) i_bitclk (
      .clk       (clk),
      .rst_n     (rst_n),
      .half_div  (clk_div),
      .sclk      (sclk),
      .rise_tick (rise_tick),
      .fall_tick (fall_tick)
   );

   fsp_txpath #(.WORD_W(WORD_W)) i_txpath (
      .clk       (clk),
      .rst_n     (rst_n),
      .fall_tick (fall_tick),
      .tx_valid  (tx_valid),
      .tx_data   (tx_data),
      .tx_ready  (tx_ready),
      .fs_n      (fs_n_int),
      .sdo       (sdo)
   );

   // receive side runs off the transmit side's own strobe and bit clock
   fsp_rxpath #(.WORD_W(WORD_W)) i_rxpath (
      .clk        (clk),
      .rst_n      (rst_n),
      .bit_strobe (rise_tick),
      .fs_n       (fs_n_int),
      .sdi        (sdi),
      .rx_valid   (rx_valid),
      .rx_data    (rx_data)
   );

   assign fs_n = fs_n_int;

endmodule

// File: rtl/fsp_master_chk.sv
module fsp_master_chk #(
   parameter int DIV_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic [DIV_W-1:0] clk_div,
   input logic             sclk,
   input logic             fs_n,
   input logic             sdo,
   input logic             tx_valid,
   input logic             tx_ready,
   input logic             rx_valid
);

   // a half period never ends after one cycle unless the divider is zero
   assert_sclk_min_half_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sclk) |=> ($stable(sclk) || ($past(clk_div) == '0)));

   assert_ready_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_valid && tx_ready) |=> !tx_ready);

   assert_fs_on_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(fs_n) |-> $fell(sclk));

   assert_frame_needs_word_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(fs_n) |-> $past(!tx_ready));

   assert_sdo_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sdo) |-> $fell(sclk));

   assert_rx_after_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> ($rose(sclk) && !$past(fs_n)));

   assert_rx_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);

endmodule

bind fsp_master fsp_master_chk #(.DIV_W(DIV_W)) i_fsp_master_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .clk_div  (clk_div),
   .sclk     (sclk),
   .fs_n     (fs_n),
   .sdo      (sdo),
   .tx_valid (tx_valid),
   .tx_ready (tx_ready),
   .rx_valid (rx_valid)
);

// File: tb/test_fsp_master.sv
`timescale 1ns/100ps
module test_fsp_master;
   localparam int W  = 16;
   localparam int DW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [DW-1:0] clk_div = 8'd3;
   logic          tx_valid = 1'b0;
   logic [W-1:0]  tx_data = '0;
   logic          sdi = 1'b0;
   logic          tx_ready, rx_valid, sclk, fs_n, sdo;
   logic [W-1:0]  rx_data;

   always #2.5 clk = ~clk;

   fsp_master #(.WORD_W(W), .DIV_W(DW)) i_fsp_master (
      .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .tx_valid(tx_valid),
      .tx_ready(tx_ready), .tx_data(tx_data), .rx_valid(rx_valid),
      .rx_data(rx_data), .sclk(sclk), .fs_n(fs_n), .sdo(sdo), .sdi(sdi)
   );

   int n_chk = 0;
   int n_fail = 0;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   endtask

   function automatic logic [W-1:0] slave_word(input int k);
      return W'(32'h3C96 ^ (k * 12059));
   endfunction

   // behavioural reference state
   logic [W-1:0] txq[$];
   logic [W-1:0] cur = '0;
   logic [W-1:0] slave_cur = '0;
   bit   in_frame = 0;
   int   rise_cnt = 0;
   int   frame_idx = 0;
   int   n_b2b = 0;
   int   since = 0;
   int   cyc = 0;
   logic prev_sclk = 1'b0, prev_fs = 1'b1, prev_sdo = 1'b0, ready_prev = 1'b1;

   always @(negedge clk) begin
      bit rose, fell, exp_rv;
      if (!rst_n) begin
         prev_sclk = 1'b0; prev_fs = 1'b1; prev_sdo = 1'b0; ready_prev = 1'b1; since = 0;
      end else begin
         cyc++;
         since++;
         rose = sclk && !prev_sclk;
         fell = !sclk && prev_sclk;
         if (sclk !== prev_sclk) begin
            chk(since == int'(clk_div) + 1, "R1/R10 half period", since, int'(clk_div) + 1);
            since = 0;
         end
         if (fell) begin
            if (in_frame && rise_cnt == W) in_frame = 0;
            if (!in_frame) begin
               if (txq.size() > 0) begin
                  cur = txq.pop_front();
                  in_frame = 1;
                  rise_cnt = 0;
                  slave_cur = slave_word(frame_idx);
                  frame_idx++;
                  if (!prev_fs) n_b2b++;
                  chk(fs_n == 1'b0, "R5/R7 fs low at frame start", fs_n, 0);
                  chk(sdo == cur[W-1], "R5 msb with fs", sdo, cur[W-1]);
                  sdi <= slave_cur[W-1];
               end else begin
                  chk(fs_n == 1'b1, "R4 no frame without word", fs_n, 1);
                  chk(sdo == prev_sdo, "R6 sdo holds when idle", sdo, prev_sdo);
               end
            end else begin
               chk(fs_n == 1'b0, "R5 fs low during word", fs_n, 0);
               chk(sdo == cur[W-1-rise_cnt], "R6 sdo bit order", sdo, cur[W-1-rise_cnt]);
               sdi <= slave_cur[W-1-rise_cnt];
            end
         end else begin
            chk(fs_n == prev_fs, "R4 fs changes only at fall", fs_n, prev_fs);
            chk(sdo == prev_sdo, "R6 sdo changes only at fall", sdo, prev_sdo);
         end
         if (rose && in_frame) begin
            rise_cnt++;
            chk(fs_n == 1'b0, "R5 fs low at rising edge", fs_n, 0);
         end
         exp_rv = rose && in_frame && (rise_cnt == W);
         chk(rx_valid == exp_rv, "R9 rx_valid timing", rx_valid, exp_rv);
         if (exp_rv) chk(rx_data == slave_cur, "R8 received word", rx_data, slave_cur);
         if (tx_valid && ready_prev) txq.push_back(tx_data);
         chk(tx_ready == (txq.size() == 0), "R3 ready tracks buffer", tx_ready, txq.size() == 0);
         prev_sclk = sclk; prev_fs = fs_n; prev_sdo = sdo; ready_prev = tx_ready;
         if (cyc > 100000) begin
            chk(0, "watchdog expired", cyc, 100000);
            summary();
         end
      end
   end

   task automatic send(input logic [W-1:0] w);
      @(negedge clk);
      tx_valid <= 1'b1;
      tx_data  <= w;
      while (!tx_ready) @(negedge clk);
      @(negedge clk);
      tx_valid <= 1'b0;
   endtask

   task automatic drain();
      while (txq.size() != 0 || in_frame) @(negedge clk);
      repeat (4 * (int'(clk_div) + 1)) @(negedge clk);
   endtask

   task automatic set_div(input logic [DW-1:0] nd);
      logic p;
      @(negedge clk);
      p = sclk;
      do @(negedge clk); while (sclk == p);
      clk_div <= nd;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      chk(sclk == 1'b0, "R2 reset sclk", sclk, 0);
      chk(fs_n == 1'b1, "R2 reset fs_n", fs_n, 1);
      chk(sdo == 1'b0, "R2 reset sdo", sdo, 0);
      chk(tx_ready == 1'b1, "R2 reset tx_ready", tx_ready, 1);
      chk(rx_valid == 1'b0, "R2 reset rx_valid", rx_valid, 0);
      rst_n <= 1'b1;
      repeat (40) @(negedge clk);
      chk(frame_idx == 0, "R4 idle without words", frame_idx, 0);
      send(16'hA5A5);
      send(16'h8001);
      send(16'hFFFF);
      send(16'h0000);
      drain();
      repeat (100) @(negedge clk);
      set_div(8'd0);
      send(16'h1234);
      send(16'hEDCB);
      drain();
      set_div(8'd7);
      send(16'h7FFE);
      drain();
      chk(frame_idx == 7, "R4 one frame per word", frame_idx, 7);
      chk(n_b2b > 0, "R7 back-to-back frames seen", n_b2b, 1);
      summary();
   end
endmodule